// File: doc/BRIEF.md
# Descriptor Slot Scan Scheduler

The scheduler owns a bank of 32 transfer-descriptor slots and decides which one an execution engine runs next. A pointer walks the slots one per cycle. A slot is dispatched when its valid input is high and its skip bit is clear. The walk returns to slot 0 after it checks a slot that software has marked as the final one. Without such a mark, the walk returns to slot 0 after slot 31. Only one slot is in flight at a time. The scheduler raises a one-cycle dispatch strobe with the slot index, then waits for the engine's completion pulse. After that pulse it resumes the walk at the slot after the one that was dispatched.

Software reaches three 32-bit maps through a small register port. The final-slot map and the skip map can be written and read back. The completion map is read-only and sticky: a completion sets the bit of its slot. A read returns the map and clears only the bits it returned. A completion that lands in the same cycle as the read is therefore kept for the next read.

Top module: `slot_scan_sched`

## Requirements
- R1: After reset the final-slot map reads 0000_0000h, the skip map reads FFFF_FFFFh and the completion map reads 0000_0000h, so no slot is dispatched until software clears skip bits.
- R2: A slot is dispatched only if its valid bit is 1 and its skip bit is 0 when the pointer reaches it.
- R3: A slot whose skip bit is 1 is never dispatched, even when its valid bit is 1.
- R4: The walk checks slots in ascending order and returns to slot 0 after checking the slot whose final-slot bit is set. With no final-slot bit set, it returns to slot 0 after slot 31.
- R5: When several final-slot bits are set, the lowest of them ends the walk. Slots above it are never dispatched.
- R6: While a slot is in flight, no further strobe is raised and the index output holds. After the completion pulse, the walk continues from the next index.
- R7: A completion pulse while a slot is in flight sets that slot's bit in the completion map. A completion pulse while nothing is in flight changes nothing.
- R8: Reading the completion map (address 2) returns its value and clears the returned bits. A second read with no new completion returns 0.
- R9: A completion in the same cycle as a completion-map read is absent from that read's data and present in the next read.
- R10: Writes to the final-slot map (address 0) and the skip map (address 1) read back as written. A write to address 2 has no effect.
- R11: The dispatch strobe is high for exactly one cycle per dispatch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slot_valid_i | input | 32 | Per-slot valid flags |
| cmpl_i | input | 1 | Completion pulse from the execution engine |
| reg_wr_i | input | 1 | Register write enable |
| reg_rd_i | input | 1 | Register read enable (clears the completion map when the address is 2) |
| reg_addr_i | input | 2 | Register address: 0 final-slot map, 1 skip map, 2 completion map |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, combinational from the address |
| disp_stb_o | output | 1 | One-cycle dispatch strobe |
| disp_idx_o | output | 5 | Index of the slot dispatched or in flight |

## Verification
The assertions assume that the engine pulses completion only for a slot it has actually received, and that reads which clear the map use address 2 only when clearing is intended. The bench raises completion for one cycle, only after it has seen a strobe, except in the deliberate idle-completion case. It drives every input on the falling edge. Each time it reconfigures the maps it first drains any slot in flight by skipping every slot and pulsing completion once. This makes the next dispatch order predictable from its own walk model.

// File: rtl/slot_scan_pkg.sv
package slot_scan_pkg;
    localparam logic [1:0] ADDR_LAST = 2'd0;
    localparam logic [1:0] ADDR_SKIP = 2'd1;
    localparam logic [1:0] ADDR_DONE = 2'd2;

    typedef enum logic {
        ST_SCAN = 1'b0,
        ST_BUSY = 1'b1
    } walk_st_e;
endpackage

// File: rtl/slot_scan_regs.sv
module slot_scan_regs
    import slot_scan_pkg::*;
#(
    parameter int NSLOT = 32,
    localparam int IDXW = $clog2(NSLOT)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             rd_en,
    input  logic [1:0]       addr,
    input  logic [NSLOT-1:0] wdata,
    output logic [NSLOT-1:0] rdata,
    input  logic             set_vld,
    input  logic [IDXW-1:0]  set_idx,
    output logic [NSLOT-1:0] last_map,
    output logic [NSLOT-1:0] skip_map
);
    typedef struct packed {
        logic [NSLOT-1:0] last;
        logic [NSLOT-1:0] skip;
        logic [NSLOT-1:0] done;
    } regs_t;

    regs_t s_d, s_q;
    logic [NSLOT-1:0] clr_mask;

    always_comb begin
        s_d = s_q;
        if (wr_en) begin
            case (addr)
                ADDR_LAST: s_d.last = wdata;
                ADDR_SKIP: s_d.skip = wdata;
                default:   ;
            endcase
        end
        // clear exactly what the read returns, then merge a new completion
        clr_mask = (rd_en && addr == ADDR_DONE) ? s_q.done : '0;
        s_d.done = s_q.done & ~clr_mask;
        if (set_vld) s_d.done[set_idx] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.last <= '0;
            s_q.skip <= '1;
            s_q.done <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        case (addr)
            ADDR_LAST: rdata = s_q.last;
            ADDR_SKIP: rdata = s_q.skip;
            ADDR_DONE: rdata = s_q.done;
            default:   rdata = '0;
        endcase
    end

    assign last_map = s_q.last;
    assign skip_map = s_q.skip;

    // R9: a completion is never lost, even when a clearing read hits the same cycle
    a_r9_cmpl_kept: assert property (@(posedge clk) disable iff (!rst_n)
        set_vld |=> s_q.done[$past(set_idx)]);

    // R8: a read with no concurrent completion empties the map
    a_r8_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == ADDR_DONE && !set_vld) |=> (s_q.done == '0));

    // R10: a write to the completion address is ignored
    a_r10_done_ro: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_DONE && !rd_en && !set_vld) |=> $stable(s_q.done));

    // R10: skip map takes the written value
    a_r10_skip_wr: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_SKIP) |=> (s_q.skip == $past(wdata)));
endmodule

// File: rtl/slot_scan_walker.sv
module slot_scan_walker
    import slot_scan_pkg::*;
#(
    parameter int NSLOT = 32,
    localparam int IDXW = $clog2(NSLOT)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NSLOT-1:0] valid_i,
    input  logic [NSLOT-1:0] skip_map,
    input  logic [NSLOT-1:0] last_map,
    input  logic             cmpl_i,
    output logic             disp_stb_o,
    output logic [IDXW-1:0]  disp_idx_o,
    output logic             done_set_o,
    output logic [IDXW-1:0]  done_idx_o
);
    localparam logic [IDXW-1:0] TOP_IDX = IDXW'(NSLOT - 1);

    typedef struct packed {
        walk_st_e        st;
        logic [IDXW-1:0] ptr;
        logic [IDXW-1:0] cur;
        logic            stb;
    } walk_t;

    walk_t w_d, w_q;
    logic            eligible;
    logic [IDXW-1:0] ptr_nxt;

    always_comb begin
        w_d      = w_q;
        w_d.stb  = 1'b0;
        eligible = valid_i[w_q.ptr] & ~skip_map[w_q.ptr];
        ptr_nxt  = (last_map[w_q.ptr] || w_q.ptr == TOP_IDX) ? '0 : w_q.ptr + 1'b1;
        case (w_q.st)
            ST_SCAN: begin
                w_d.ptr = ptr_nxt;
                if (eligible) begin
                    w_d.st  = ST_BUSY;
                    w_d.cur = w_q.ptr;
                    w_d.stb = 1'b1;
                end
            end
            ST_BUSY: begin
                if (cmpl_i) w_d.st = ST_SCAN;
            end
            default: w_d.st = ST_SCAN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            w_q.st  <= ST_SCAN;
            w_q.ptr <= '0;
            w_q.cur <= '0;
            w_q.stb <= 1'b0;
        end else begin
            w_q <= w_d;
        end
    end

    assign disp_stb_o = w_q.stb;
    assign disp_idx_o = w_q.cur;
    assign done_set_o = (w_q.st == ST_BUSY) && cmpl_i;
    assign done_idx_o = w_q.cur;

    // R11: strobe never lasts two cycles
    a_r11_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        disp_stb_o |=> !disp_stb_o);

    // R6: nothing new while a slot is in flight
    a_r6_hold_in_flight: assert property (@(posedge clk) disable iff (!rst_n)
        (w_q.st == ST_BUSY && !cmpl_i) |=> (!disp_stb_o && $stable(disp_idx_o)));
endmodule

// File: rtl/slot_scan_sched.sv
module slot_scan_sched (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [31:0] slot_valid_i,
    input  logic        cmpl_i,
    input  logic        reg_wr_i,
    input  logic        reg_rd_i,
    input  logic [1:0]  reg_addr_i,
    input  logic [31:0] reg_wdata_i,
    output logic [31:0] reg_rdata_o,
    output logic        disp_stb_o,
    output logic [4:0]  disp_idx_o
);
    localparam int NSLOT = 32;
    localparam int IDXW  = $clog2(NSLOT);

    logic [NSLOT-1:0] last_map, skip_map;
    logic             done_set;
    logic [IDXW-1:0]  done_idx;

    slot_scan_regs #(.NSLOT(NSLOT)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (reg_wr_i),
        .rd_en    (reg_rd_i),
        .addr     (reg_addr_i),
        .wdata    (reg_wdata_i),
        .rdata    (reg_rdata_o),
        .set_vld  (done_set),
        .set_idx  (done_idx),
        .last_map (last_map),
        .skip_map (skip_map)
    );

    slot_scan_walker #(.NSLOT(NSLOT)) u_walker (
        .clk        (clk),
        .rst_n      (rst_n),
        .valid_i    (slot_valid_i),
        .skip_map   (skip_map),
        .last_map   (last_map),
        .cmpl_i     (cmpl_i),
        .disp_stb_o (disp_stb_o),
        .disp_idx_o (disp_idx_o),
        .done_set_o (done_set),
        .done_idx_o (done_idx)
    );

    // eligibility seen by the walker one cycle before each strobe
    logic [NSLOT-1:0] elig_prev_q;
    always_ff @(posedge clk) begin
        if (!rst_n) elig_prev_q <= '0;
        else        elig_prev_q <= slot_valid_i & ~skip_map;
    end

    // R2, R3: every dispatched slot was valid and unskipped when checked
    a_r2_dispatch_eligible: assert property (@(posedge clk) disable iff (!rst_n)
        disp_stb_o |-> elig_prev_q[disp_idx_o]);
endmodule

// File: tb/slot_scan_sched_bench.sv
`timescale 1ns/1ps
module slot_scan_sched_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] slot_valid_i = '0;
    logic        cmpl_i = 1'b0;
    logic        reg_wr_i = 1'b0;
    logic        reg_rd_i = 1'b0;
    logic [1:0]  reg_addr_i = '0;
    logic [31:0] reg_wdata_i = '0;
    logic [31:0] reg_rdata_o;
    logic        disp_stb_o;
    logic [4:0]  disp_idx_o;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;
    logic [31:0] cfg_valid, cfg_skip, cfg_last;

    always #10 clk = ~clk;

    slot_scan_sched u_slot_scan_sched (.*);

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    task automatic reg_write(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr_i = a; reg_wdata_i = d; reg_wr_i = 1'b1;
        @(negedge clk);
        reg_wr_i = 1'b0;
    endtask

    task automatic reg_read(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr_i = a; reg_rd_i = 1'b1;
        #1 d = reg_rdata_o;
        @(negedge clk);
        reg_rd_i = 1'b0;
    endtask

    function automatic int next_elig(input int prev);
        int i = prev;
        for (int k = 0; k < 70; k++) begin
            if (cfg_last[i] || i == 31) i = 0; else i++;
            if (cfg_valid[i] && !cfg_skip[i]) return i;
        end
        return -1;
    endfunction

    task automatic drain();
        logic [31:0] d;
        reg_write(2'd1, 32'hFFFF_FFFF);
        @(negedge clk); cmpl_i = 1'b1;
        @(negedge clk); cmpl_i = 1'b0;
        reg_read(2'd2, d);
    endtask

    task automatic setup(input logic [31:0] v, input logic [31:0] s, input logic [31:0] l);
        drain();
        cfg_valid = v; cfg_skip = s; cfg_last = l;
        slot_valid_i = v;
        reg_write(2'd0, l);
        reg_write(2'd1, s);
    endtask

    task automatic wait_dispatch(input bit complete, input string tag, output int idx);
        bit seen = 0;
        idx = -1;
        for (int c = 0; c < 200; c++) begin
            @(negedge clk);
            if (disp_stb_o) begin seen = 1; break; end
        end
        chk(seen, {tag, " dispatch seen"}, 32'(seen), 32'd1);
        if (!seen) return;
        idx = int'(disp_idx_o);
        @(negedge clk);
        chk(!disp_stb_o, "R11 strobe one cycle", 32'(disp_stb_o), 32'd0);
        for (int c = 0; c < 4; c++) begin
            @(negedge clk);
            chk(!disp_stb_o && int'(disp_idx_o) == idx, "R6 hold while in flight",
                {27'd0, disp_idx_o}, 32'(idx));
        end
        if (complete) begin
            cmpl_i = 1'b1;
            @(negedge clk);
            cmpl_i = 1'b0;
        end
    endtask

    task automatic order_run(input int n, input string tag);
        int idx, prev;
        wait_dispatch(1, tag, idx);
        chk(idx >= 0 && cfg_valid[idx] && !cfg_skip[idx], {tag, " first eligible"}, 32'(idx), 32'(idx));
        prev = idx;
        for (int k = 1; k < n; k++) begin
            wait_dispatch(1, tag, idx);
            chk(idx == next_elig(prev), {tag, " order"}, 32'(idx), 32'(next_elig(prev)));
            prev = idx;
        end
    endtask

    task automatic t_reset();
        logic [31:0] d;
        bit any = 0;
        reg_read(2'd0, d); chk(d == 32'h0, "R1 last reset", d, 32'h0);
        reg_read(2'd1, d); chk(d == 32'hFFFF_FFFF, "R1 skip reset", d, 32'hFFFF_FFFF);
        reg_read(2'd2, d); chk(d == 32'h0, "R1 done reset", d, 32'h0);
        slot_valid_i = '1;
        for (int c = 0; c < 40; c++) begin @(negedge clk); if (disp_stb_o) any = 1; end
        chk(!any, "R1 no dispatch while all skipped", 32'(any), 32'd0);
    endtask

    task automatic t_basic();
        setup(32'h0000_0024, 32'h0, 32'h0000_0080);
        order_run(5, "R2 R4 basic");
    endtask

    task automatic t_skip();
        int idx;
        setup(32'h0000_0024, 32'h0000_0020, 32'h0000_0080);
        for (int k = 0; k < 3; k++) begin
            wait_dispatch(1, "R3", idx);
            chk(idx == 2, "R3 skipped slot passed over", 32'(idx), 32'd2);
        end
    endtask

    task automatic t_nolast();
        setup(32'h4000_0002, 32'h0, 32'h0);
        order_run(4, "R4 full sweep");
    endtask

    task automatic t_lowest_last();
        int idx;
        setup(32'h0000_0402, 32'h0, 32'h0010_0008);
        for (int k = 0; k < 3; k++) begin
            wait_dispatch(1, "R5", idx);
            chk(idx == 1, "R5 lowest final bit ends walk", 32'(idx), 32'd1);
        end
    endtask

    task automatic t_done();
        int idx;
        logic [31:0] d;
        setup(32'h0000_0040, 32'h0, 32'h0);
        reg_read(2'd2, d);
        wait_dispatch(1, "R7", idx);
        reg_write(2'd1, 32'hFFFF_FFFF);
        reg_read(2'd2, d); chk(d == 32'h0000_0040, "R7 R8 completion bit", d, 32'h0000_0040);
        reg_read(2'd2, d); chk(d == 32'h0, "R8 second read empty", d, 32'h0);
        @(negedge clk); cmpl_i = 1'b1;
        @(negedge clk); cmpl_i = 1'b0;
        reg_read(2'd2, d); chk(d == 32'h0, "R7 idle completion ignored", d, 32'h0);
    endtask

    task automatic t_race();
        int idx;
        logic [31:0] d;
        setup(32'h0000_0010, 32'h0, 32'h0);
        wait_dispatch(1, "R9", idx);
        wait_dispatch(0, "R9", idx);
        @(negedge clk);
        cmpl_i = 1'b1; reg_addr_i = 2'd2; reg_rd_i = 1'b1;
        #1 d = reg_rdata_o;
        chk(d == 32'h0000_0010, "R9 read data before race", d, 32'h0000_0010);
        @(negedge clk);
        cmpl_i = 1'b0; reg_rd_i = 1'b0;
        reg_write(2'd1, 32'hFFFF_FFFF);
        reg_read(2'd2, d); chk(d == 32'h0000_0010, "R9 racing completion kept", d, 32'h0000_0010);
    endtask

    task automatic t_regs();
        logic [31:0] d;
        drain();
        reg_write(2'd0, 32'h1234_5678);
        reg_read(2'd0, d); chk(d == 32'h1234_5678, "R10 final map readback", d, 32'h1234_5678);
        reg_write(2'd1, 32'hA5A5_0F0F);
        reg_read(2'd1, d); chk(d == 32'hA5A5_0F0F, "R10 skip map readback", d, 32'hA5A5_0F0F);
        slot_valid_i = '0;
        reg_write(2'd2, 32'hFFFF_FFFF);
        reg_read(2'd2, d); chk(d == 32'h0, "R10 completion map not writable", d, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_basic();
        t_skip();
        t_nolast();
        t_lowest_last();
        t_done();
        t_race();
        t_regs();
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog expired actual=%08h expected=%08h", 32'd1, 32'd0);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule